// File: doc/BRIEF.md
# Lane Reduction Sequencer

This block steers one lane of a multi-lane vector unit through a reduction. When a reduction operation starts, it first adds up the lane's own 64-bit operand words. The add is done element by element, at the element width chosen for the operation. It then trades partial results with the other lanes through a neighbour-exchange unit. The exchange takes log2(NUM_LANES) rounds, and each round is one send handshake followed by one receive handshake.

In lane 0 the final 64-bit word is then folded down to a single element, halving the active width each cycle. The scalar result is offered on a commit handshake. Other lanes go back to idle once their last exchange round ends. The arithmetic is a plain wrap-around add.

Top module: `lane_reduce_seq`

## Requirements
- R1: During and after reset, `phase` reads 0 (idle) and `opReady`, `txValid`, `rxReady` and `resValid` are low.
- R2: In idle, a start with `isReduction` low is ignored: `phase` stays 0 and no handshake output rises.
- R3: A start with `isReduction` high latches `sew` (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit elements) and `elemCount`, and clears the accumulator. It then enters the local phase (`phase` = 1). There `opReady` is high while words remain, and each accepted `opData` word is added to the accumulator element-wise, modulo the element width. Exactly `elemCount` words are taken; a count of 0 takes none.
- R4: When no local words remain, the block enters the send phase (`phase` = 2). It raises `txValid` with `txData` equal to the accumulator, and holds both unchanged until `txReady` is seen.
- R5: After a send is accepted, the block enters the receive phase (`phase` = 3) with `rxReady` high. An `rxValid` word is added to the accumulator element-wise. Send and receive repeat for log2(NUM_LANES) rounds in total.
- R6: In a lane other than 0, the last receive returns the block to idle, and `resValid` never rises.
- R7: In lane 0, the last receive starts folding (`phase` = 4). Each fold cycle adds the upper half of the active width to the lower half, element-wise. Folding takes 3 − `sew` cycles, so 64-bit elements skip it.
- R8: Lane 0 then commits (`phase` = 5). It holds `resValid` high, with `resData` equal to the sum of all elements of the final word modulo the element width (zero-extended), until `resReady` is seen. It then returns to idle.
- R9: At most one of `opReady`, `txValid`, `rxReady` and `resValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation start pulse, sampled in idle |
| isReduction | input | 1 | Started operation is a reduction |
| sew | input | 2 | Element width code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| elemCount | input | CNT_W | Number of 64-bit words this lane accumulates |
| opValid | input | 1 | Local operand word valid |
| opData | input | 64 | Local operand word |
| opReady | output | 1 | Local operand accepted this cycle when valid |
| txValid | output | 1 | Partial result offered to the exchange unit |
| txData | output | 64 | Partial result word |
| txReady | input | 1 | Exchange unit takes the partial result |
| rxValid | input | 1 | Neighbour partial result valid |
| rxData | input | 64 | Neighbour partial result word |
| rxReady | output | 1 | Block takes the neighbour word |
| resValid | output | 1 | Scalar result valid (lane 0 only) |
| resData | output | 64 | Scalar result, zero-extended element |
| resReady | input | 1 | Consumer takes the scalar result |
| phase | output | 3 | Current phase: 0 idle, 1 local, 2 send, 3 receive, 4 fold, 5 commit |

## Verification
Several behaviours are checked on every cycle:
- ignored non-reduction starts;
- the hold of `txValid`/`txData` and of `resValid`/`resData` under back-pressure;
- the mutual exclusion of the four handshake outputs;
- that `opReady` appears only in the local phase;
- the return to idle after a commit.

Other behaviours are shown only by the bench's scenarios: the arithmetic value of each exchanged partial and of the folded scalar, the exact number of operand words taken, the number of exchange rounds, the fold cycle count for each element width, and the silent idle return of a non-zero lane.

// File: rtl/lane_reduce_pkg.sv
package lane_reduce_pkg;

  localparam int WORD_W = 64;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOCAL  = 3'd1,
    PH_SEND   = 3'd2,
    PH_RECV   = 3'd3,
    PH_FOLD   = 3'd4,
    PH_COMMIT = 3'd5
  } phase_e;

  // Strobes from control to the accumulator datapath
  typedef struct packed {
    logic       clr;
    logic       addOp;
    logic       addRx;
    logic       fold;
    logic [1:0] foldLvl;  // 3: 64->32, 2: 32->16, 1: 16->8
  } acc_ctl_t;

  // Element-wise add; carries are cut at element boundaries
  function automatic logic [WORD_W-1:0] simdAdd(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b,
                                                input logic [1:0] sew);
    logic [WORD_W-1:0] s;
    logic [8:0] t;
    logic c;
    s = '0;
    c = 1'b0;
    for (int i = 0; i < WORD_W / 8; i++) begin
      t = {1'b0, a[i*8 +: 8]} + {1'b0, b[i*8 +: 8]} + {8'd0, c};
      s[i*8 +: 8] = t[7:0];
      c = (((i + 1) % (1 << sew)) == 0) ? 1'b0 : t[8];
    end
    return s;
  endfunction

endpackage

// File: rtl/lane_reduce_dp.sv
module lane_reduce_dp
  import lane_reduce_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  acc_ctl_t          ctl,
  input  logic [1:0]        sew,
  input  logic [WORD_W-1:0] opData,
  input  logic [WORD_W-1:0] rxData,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] resData
);

  logic [WORD_W-1:0] foldVal;
  logic [WORD_W-1:0] foldMask;
  logic [WORD_W-1:0] elemMask;
  int                half;

  always_comb begin
    half     = 4 << ctl.foldLvl;
    foldMask = (64'd1 << half) - 64'd1;
    foldVal  = simdAdd(acc & foldMask, acc >> half, sew) & foldMask;
    elemMask = (sew == 2'd3) ? '1 : ((64'd1 << (8 << sew)) - 64'd1);
    resData  = acc & elemMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          acc <= '0;
    else if (ctl.clr)   acc <= '0;
    else if (ctl.addOp) acc <= simdAdd(acc, opData, sew);
    else if (ctl.addRx) acc <= simdAdd(acc, rxData, sew);
    else if (ctl.fold)  acc <= foldVal;
  end

endmodule

// File: rtl/lane_reduce_ctrl.sv
module lane_reduce_ctrl
  import lane_reduce_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isReduction,
  input  logic [1:0]       sew,
  input  logic [CNT_W-1:0] elemCount,
  input  logic             opValid,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic             resReady,
  output logic             opReady,
  output logic             txValid,
  output logic             rxReady,
  output logic             resValid,
  output logic [1:0]       sewQ,
  output acc_ctl_t         ctl,
  output logic [2:0]       phase
);

  localparam int ROUNDS = $clog2(NUM_LANES);
  localparam int RCNT_W = $clog2(ROUNDS + 1);
  localparam logic [RCNT_W-1:0] LAST_RND = RCNT_W'(ROUNDS - 1);
  localparam bit IS_LANE0 = (LANE_ID == 0);

  phase_e           state, nextState;
  logic [CNT_W-1:0] wordsLeft;
  logic [RCNT_W-1:0] rxCnt;
  logic [1:0]       foldLvl;

  assign phase    = state;
  assign opReady  = (state == PH_LOCAL) && (wordsLeft != '0);
  assign txValid  = (state == PH_SEND);
  assign rxReady  = (state == PH_RECV);
  assign resValid = (state == PH_COMMIT);

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.foldLvl = foldLvl;
    unique case (state)
      PH_IDLE: if (start && isReduction) begin
        ctl.clr   = 1'b1;
        nextState = PH_LOCAL;
      end
      PH_LOCAL: begin
        if (wordsLeft == '0) nextState = PH_SEND;
        else if (opValid)    ctl.addOp = 1'b1;
      end
      PH_SEND: if (txReady) nextState = PH_RECV;
      PH_RECV: if (rxValid) begin
        ctl.addRx = 1'b1;
        if (rxCnt != LAST_RND)  nextState = PH_SEND;
        else if (!IS_LANE0)     nextState = PH_IDLE;
        else if (sewQ == 2'd3)  nextState = PH_COMMIT;
        else                    nextState = PH_FOLD;
      end
      PH_FOLD: begin
        ctl.fold = 1'b1;
        if (foldLvl - 2'd1 == sewQ) nextState = PH_COMMIT;
      end
      PH_COMMIT: if (resReady) nextState = PH_IDLE;
      default: nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      wordsLeft <= '0;
      rxCnt     <= '0;
      foldLvl   <= 2'd3;
      sewQ      <= 2'd0;
    end else begin
      state <= nextState;
      if (state == PH_IDLE && start && isReduction) begin
        wordsLeft <= elemCount;
        sewQ      <= sew;
        rxCnt     <= '0;
        foldLvl   <= 2'd3;
      end
      if (ctl.addOp) wordsLeft <= wordsLeft - 1'b1;
      if (ctl.addRx) rxCnt <= rxCnt + 1'b1;
      if (ctl.fold)  foldLvl <= foldLvl - 2'd1;
    end
  end

endmodule

// File: rtl/lane_reduce_seq.sv
module lane_reduce_seq
  import lane_reduce_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int MAX_WORDS = 64,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isReduction,
  input  logic [1:0]       sew,
  input  logic [CNT_W-1:0] elemCount,
  input  logic             opValid,
  input  logic [63:0]      opData,
  output logic             opReady,
  output logic             txValid,
  output logic [63:0]      txData,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic [63:0]      rxData,
  output logic             rxReady,
  output logic             resValid,
  output logic [63:0]      resData,
  input  logic             resReady,
  output logic [2:0]       phase
);

  acc_ctl_t   ctl;
  logic [1:0] sewQ;
  logic [63:0] acc;

  lane_reduce_ctrl #(
    .NUM_LANES(NUM_LANES), .LANE_ID(LANE_ID), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isReduction(isReduction),
    .sew(sew), .elemCount(elemCount), .opValid(opValid),
    .txReady(txReady), .rxValid(rxValid), .resReady(resReady),
    .opReady(opReady), .txValid(txValid), .rxReady(rxReady),
    .resValid(resValid), .sewQ(sewQ), .ctl(ctl), .phase(phase)
  );

  lane_reduce_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sew(sewQ),
    .opData(opData), .rxData(rxData), .acc(acc), .resData(resData)
  );

  assign txData = acc;

endmodule

// File: rtl/lane_reduce_chk.sv
module lane_reduce_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        isReduction,
  input logic        opReady,
  input logic        txValid,
  input logic [63:0] txData,
  input logic        txReady,
  input logic        rxReady,
  input logic        resValid,
  input logic [63:0] resData,
  input logic        resReady,
  input logic [2:0]  phase
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 && !(start && isReduction)) |=> (phase == 3'd0));

  assert_op_local_R3: assert property (@(posedge clk) disable iff (!rstN)
    opReady |-> (phase == 3'd1));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData)));

  assert_commit_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resReady) |=> (phase == 3'd0 && !resValid));

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opReady, txValid, rxReady, resValid}));

endmodule

bind lane_reduce_seq lane_reduce_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .isReduction(isReduction),
  .opReady(opReady), .txValid(txValid), .txData(txData), .txReady(txReady),
  .rxReady(rxReady), .resValid(resValid), .resData(resData),
  .resReady(resReady), .phase(phase)
);

// File: tb/lane_reduce_seq_tb.sv
module lane_reduce_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // lane 0 signals
  logic        start = 0, isRed = 0, opValid = 0, txReady = 0, rxValid = 0, resReady = 0;
  logic [1:0]  sew = 0;
  logic [6:0]  cnt = 0;
  logic [63:0] opData = 0, rxData = 0;
  logic        opReady, txValid, rxReady, resValid;
  logic [63:0] txData, resData;
  logic [2:0]  phase;

  // lane 1 signals
  logic        bStart = 0, bOpValid = 0, bTxReady = 0, bRxValid = 0;
  logic [6:0]  bCnt = 0;
  logic [63:0] bOpData = 0, bRxData = 0;
  logic        bOpReady, bTxValid, bRxReady, bResValid;
  logic [63:0] bTxData, bResData;
  logic [2:0]  bPhase;

  lane_reduce_seq #(.NUM_LANES(4), .LANE_ID(0)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isReduction(isRed), .sew(sew),
    .elemCount(cnt), .opValid(opValid), .opData(opData), .opReady(opReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxValid(rxValid),
    .rxData(rxData), .rxReady(rxReady), .resValid(resValid), .resData(resData),
    .resReady(resReady), .phase(phase)
  );

  lane_reduce_seq #(.NUM_LANES(4), .LANE_ID(1)) u_dut_b (
    .clk(clk), .rstN(rstN), .start(bStart), .isReduction(1'b1), .sew(2'd1),
    .elemCount(bCnt), .opValid(bOpValid), .opData(bOpData), .opReady(bOpReady),
    .txValid(bTxValid), .txData(bTxData), .txReady(bTxReady), .rxValid(bRxValid),
    .rxData(bRxData), .rxReady(bRxReady), .resValid(bResValid), .resData(bResData),
    .resReady(1'b1), .phase(bPhase)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] emask(input int s);
    return (s == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  // element-wise sum, elements taken out one at a time
  function automatic logic [63:0] ewAdd(input logic [63:0] a, input logic [63:0] b, input int s);
    logic [63:0] r = '0;
    int w = 8 << s;
    for (int k = 0; k < (8 >> s); k++)
      r |= (((a >> (k * w)) + (b >> (k * w))) & emask(s)) << (k * w);
    return r;
  endfunction

  function automatic logic [63:0] allSum(input logic [63:0] a, input int s);
    logic [63:0] r = '0;
    int w = 8 << s;
    for (int k = 0; k < (8 >> s); k++) r = (r + (a >> (k * w))) & emask(s);
    return r;
  endfunction

  task automatic waitPhase(input logic [2:0] p);
    for (int i = 0; i < 20 && phase != p; i++) @(negedge clk);
  endtask

  task automatic runLane0(input int s, input int n, input int txStall, input int resStall);
    logic [63:0] model = '0;
    logic [63:0] w;
    int folds = 0;
    bit sawOpEarly = 0;
    @(negedge clk);
    start = 1; isRed = 1; sew = 2'(s); cnt = 7'(n);
    @(negedge clk);
    start = 0; sew = 2'(3 - s);  // later changes must not matter
    chk(phase == 3'd1, "R3 enter local", 64'(phase), 64'd1);
    for (int i = 0; i < n; i++) begin
      w = {$urandom, $urandom};
      opValid = 1; opData = w;
      if (!opReady) sawOpEarly = 1;
      model = ewAdd(model, w, s);
      @(negedge clk);
    end
    opValid = 1; opData = 64'hFFFF_FFFF_FFFF_FFFF;  // extra word offered, must be refused
    waitPhase(3'd2);
    opValid = 0;
    chk(!sawOpEarly, "R3 opReady while words remain", 64'(sawOpEarly), 64'd0);
    for (int r = 0; r < 2; r++) begin
      chk(phase == 3'd2 && txValid, "R4 send phase", 64'(phase), 64'd2);
      chk(txData == model, "R4 txData partial", txData, model);
      for (int k = 0; k < txStall; k++) begin
        @(negedge clk);
        chk(txValid && txData == model, "R4 hold under stall", txData, model);
      end
      txReady = 1;
      @(negedge clk);
      txReady = 0;
      chk(phase == 3'd3 && rxReady, "R5 receive phase", 64'(phase), 64'd3);
      w = {$urandom, $urandom};
      rxValid = 1; rxData = w;
      model = ewAdd(model, w, s);
      @(negedge clk);
      rxValid = 0;
    end
    while (phase == 3'd4 && folds < 8) begin
      folds++;
      @(negedge clk);
    end
    chk(folds == 3 - s, "R7 fold cycles", 64'(folds), 64'(3 - s));
    chk(phase == 3'd5 && resValid, "R8 commit phase", 64'(phase), 64'd5);
    chk(resData == allSum(model, s), "R8 result", resData, allSum(model, s));
    for (int k = 0; k < resStall; k++) begin
      @(negedge clk);
      chk(resValid && resData == allSum(model, s), "R8 hold under stall", resData, allSum(model, s));
    end
    resReady = 1;
    @(negedge clk);
    resReady = 0;
    chk(phase == 3'd0 && !resValid, "R8 back to idle", 64'(phase), 64'd0);
  endtask

  task automatic runLane1(input int n);
    logic [63:0] model = '0;
    logic [63:0] w;
    bit sawRes = 0;
    @(negedge clk);
    bStart = 1; bCnt = 7'(n);
    @(negedge clk);
    bStart = 0;
    for (int i = 0; i < n; i++) begin
      w = {$urandom, $urandom};
      bOpValid = 1; bOpData = w; model = ewAdd(model, w, 1);
      @(negedge clk);
    end
    bOpValid = 0;
    for (int i = 0; i < 5 && bPhase != 3'd2; i++) @(negedge clk);
    for (int r = 0; r < 2; r++) begin
      chk(bTxValid && bTxData == model, "R5 lane1 txData", bTxData, model);
      bTxReady = 1; @(negedge clk); bTxReady = 0;
      w = {$urandom, $urandom};
      bRxValid = 1; bRxData = w; model = ewAdd(model, w, 1);
      @(negedge clk);
      bRxValid = 0;
    end
    for (int i = 0; i < 6; i++) begin
      if (bResValid) sawRes = 1;
      @(negedge clk);
    end
    chk(bPhase == 3'd0, "R6 lane1 idle after rounds", 64'(bPhase), 64'd0);
    chk(!sawRes, "R6 lane1 no result", 64'(sawRes), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && !opReady && !txValid && !rxReady && !resValid, "R1 reset state",
        64'(phase), 64'd0);
    rstN = 1;
    @(negedge clk);
    chk(phase == 3'd0 && !resValid, "R1 after reset", 64'(phase), 64'd0);
    // R2: non-reduction start ignored
    start = 1; isRed = 0; cnt = 7'd3;
    @(negedge clk);
    start = 0;
    chk(phase == 3'd0 && !opReady && !txValid, "R2 non-reduction ignored", 64'(phase), 64'd0);
    @(negedge clk);
    chk(phase == 3'd0, "R2 still idle", 64'(phase), 64'd0);
    // near-exhaustive sweep over element width and word count
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 6; n++)
        runLane0(s, n, n % 3, (s + n) % 3);
    runLane1(0);
    runLane1(3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule